// File: doc/BRIEF.md
# Asynchronous External Memory Bus Controller

This block turns single-request transfers from an on-chip master into timed cycles on an asynchronous external memory bus. The master presents a 20-bit byte address, up to two bytes of write data with a byte-enable pair, and a read/write flag. It holds `cpu_req` until `cpu_ack` is returned. The controller breaks the transfer into one or two external bus cycles. Each cycle has one address cycle marked by `ale`, then a data phase that lasts at least one clock and is stretched while `rdy_n` is low. Four active-low chip selects come from programmable page windows.

Three static inputs shape the bus. `narrow_sel` selects an 8-bit or a 16-bit data bus. `mux_sel` makes the low data byte carry the address during the `ale` cycle. `strobe_sel` picks between two strobe styles. One style has a separate write strobe for each byte lane. The other has a single write strobe together with a byte-high enable. An external master can take the bus with `hold_n`. The controller grants it only between transfers, answers on `hlda_n` and releases every output it drives. Pad electrical behaviour is outside the block: each driven group has its own output-enable signal.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Byte lanes: with `narrow_sel`=0 (16-bit bus) a byte at an even address travels on `ext_dout/ext_din[7:0]` and a byte at an odd address on `[15:8]`. With `narrow_sel`=1 (8-bit bus) every byte travels on `[7:0]` and `ext_dout_oe[1]` stays 0. During a write data phase `ext_dout_oe` shows exactly the active lanes (bit 0 low lane, bit 1 high lane). During a read data phase it is 0.
- R2: `ext_addr` carries the 20-bit byte address of the current bus cycle through its address and data phases. In `cpu_wdata`/`cpu_rdata`, bits [7:0] belong to `cpu_addr` (enabled by `cpu_be[0]`) and bits [15:8] to `cpu_addr`+1 (enabled by `cpu_be[1]`).
- R3: Lane-strobe style (`strobe_sel`=0 on a 16-bit bus): `strobe_a_n` is low in the data phase of a write that uses the low lane. `strobe_b_n` is low in the data phase of a write that uses the high lane. `rd_n` is low in the data phase of every read, and no write strobe is low during a read.
- R4: Write/byte-high style (`strobe_sel`=1): `strobe_a_n` is low in the data phase of every write. `strobe_b_n` is low through the address and data phases of every bus cycle that touches an odd-addressed byte, for reads and writes alike. `rd_n` behaves as in R3.
- R5: With `narrow_sel`=1 the write/byte-high style of R4 applies whatever the value of `strobe_sel`.
- R6: With `mux_sel`=1, during the `ale` cycle `ext_dout[7:0]` is driven (`ext_dout_oe[0]`=1) with address bits 7..0 on an 8-bit bus or address bits 8..1 on a 16-bit bus. `ale` is high for exactly one clock at the start of every bus cycle.
- R7: Each bus cycle is one `ale` clock followed by a data phase of 1+N clocks, where N is the number of data-phase clocks in which `rdy_n` was sampled low. Address and strobes stay unchanged while the cycle is stretched.
- R8: `cpu_ack` is high for one clock, the final data clock of the last bus cycle of the transfer. In that clock `cpu_rdata` holds the read bytes, with disabled bytes as zero. An unheld transfer starting from idle acknowledges B*(2+N)+1 clocks after `cpu_req` is raised, where B is the number of bus cycles.
- R9: A transfer is one bus cycle when only one byte is enabled, or when both are enabled on a 16-bit bus at an even address. Otherwise it is two byte cycles, `cpu_addr` first and then `cpu_addr`+1.
- R10: `hold_n` low is granted only when no transfer is in progress. While granted, `hlda_n` is low, `ext_addr_oe`, `ext_dout_oe` and `ctrl_oe` are 0, and no new transfer starts. A request made during hold starts after `hold_n` returns high.
- R11: Chip select i (`cs_n[i]`) is low during a bus cycle whose address page `ext_addr[19:12]` lies in [base_i, base_i+len_i). Here base_i is `cs_base[8i+7:8i]` and len_i is `cs_len[8i+7:8i]`. The lowest matching index wins. No select is low between cycles or when no window matches.
- R12: After reset the controller is idle: `cpu_ack`=0, `ale`=0, `rd_n`, `strobe_a_n`, `strobe_b_n`, `hlda_n` high, `cs_n` all high, `ext_dout_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Transfer request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Byte address of the transfer |
| cpu_wdata | input | 16 | Write bytes (see R2) |
| cpu_be | input | 2 | Byte enables (see R2) |
| cpu_ack | output | 1 | Transfer complete |
| cpu_rdata | output | 16 | Read bytes, valid with `cpu_ack` |
| narrow_sel | input | 1 | 1 = 8-bit external bus, 0 = 16-bit |
| mux_sel | input | 1 | 1 = address shared on low data byte |
| strobe_sel | input | 1 | 1 = write/byte-high strobe style |
| cs_base | input | 32 | Four 8-bit page bases |
| cs_len | input | 32 | Four 8-bit page counts |
| ext_addr | output | 20 | External address |
| ext_addr_oe | output | 1 | Address output enable |
| ext_dout | output | 16 | External data / shared address out |
| ext_dout_oe | output | 2 | Per-lane data output enable |
| ext_din | input | 16 | External data in |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe |
| strobe_a_n | output | 1 | Low-lane write / common write strobe |
| strobe_b_n | output | 1 | High-lane write / byte-high enable |
| cs_n | output | 4 | Chip selects |
| ctrl_oe | output | 1 | Strobe and select output enable |
| rdy_n | input | 1 | Low = stretch data phase |
| hold_n | input | 1 | Low = bus hold request |
| hlda_n | output | 1 | Low = hold granted |

## Verification
The assertions assume that `narrow_sel`, `mux_sel`, `strobe_sel` and the window inputs stay stable while a transfer is in flight. They also assume that `cpu_req` is never raised with both byte enables clear, and that it stays high until `cpu_ack` and falls in the following clock. The stimulus changes the bus configuration only while the controller is idle and every request has a nonzero enable pair. The request is dropped on the edge after the acknowledge. `rdy_n` is driven from a per-cycle wait count started at each `ale`, so stretching never starts before the data phase.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int AW  = 20,
  parameter int NCS = 4,
  parameter int PW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [15:0]      cpu_wdata,
  input  logic [1:0]       cpu_be,
  output logic             cpu_ack,
  output logic [15:0]      cpu_rdata,
  input  logic             narrow_sel,
  input  logic             mux_sel,
  input  logic             strobe_sel,
  input  logic [NCS*PW-1:0] cs_base,
  input  logic [NCS*PW-1:0] cs_len,
  output logic [AW-1:0]    ext_addr,
  output logic             ext_addr_oe,
  output logic [15:0]      ext_dout,
  output logic [1:0]       ext_dout_oe,
  input  logic [15:0]      ext_din,
  output logic             ale,
  output logic             rd_n,
  output logic             strobe_a_n,
  output logic             strobe_b_n,
  output logic [NCS-1:0]   cs_n,
  output logic             ctrl_oe,
  input  logic             rdy_n,
  input  logic             hold_n,
  output logic             hlda_n
);

  localparam int BW   = 8;
  localparam int PLSB = AW - PW;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_HOLD} st_t;

  st_t           st;
  logic [AW-1:0] a_q;
  logic          we_q;
  logic [15:0]   wd_q;
  logic [1:0]    be_q;
  logic          beat_q;
  logic [BW-1:0] rd0_q;

  logic          busy, in_data, comb, two, hi_sel, last, sty, odd_touch;
  logic          lane_lo, lane_hi;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] cur_wbyte, cur_rbyte, maddr, rlo, rhi;
  logic [PW-1:0] page;
  logic [NCS-1:0] hit, cs_sel;

  assign busy    = (st == S_ADDR) || (st == S_DATA);
  assign in_data = (st == S_DATA);
  assign comb    = !narrow_sel && !a_q[0] && (be_q == 2'b11);
  assign two     = (be_q == 2'b11) && !comb;
  assign hi_sel  = beat_q || !be_q[0];
  assign cur_addr = hi_sel ? a_q + AW'(1) : a_q;
  assign last    = in_data && rdy_n && (!two || beat_q);
  assign sty     = narrow_sel || strobe_sel;

  assign lane_lo = busy && (narrow_sel || comb || !cur_addr[0]);
  assign lane_hi = busy && !narrow_sel && (comb || cur_addr[0]);
  assign odd_touch = narrow_sel ? cur_addr[0] : lane_hi;

  assign cur_wbyte = hi_sel ? wd_q[15:8] : wd_q[7:0];
  assign cur_rbyte = (narrow_sel || !cur_addr[0]) ? ext_din[7:0] : ext_din[15:8];
  assign maddr     = narrow_sel ? cur_addr[7:0] : cur_addr[8:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      be_q   <= '0;
      beat_q <= 1'b0;
      rd0_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          beat_q <= 1'b0;
          if (!hold_n) st <= S_HOLD;
          else if (cpu_req) begin
            a_q  <= cpu_addr;
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
            be_q <= cpu_be;
            st   <= S_ADDR;
          end
        end
        S_HOLD: if (hold_n) st <= S_IDLE;
        S_ADDR: st <= S_DATA;
        S_DATA: if (rdy_n) begin
          if (two && !beat_q) begin
            beat_q <= 1'b1;
            rd0_q  <= cur_rbyte;
            st     <= S_ADDR;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rlo = comb ? ext_din[7:0]  : two ? rd0_q : (be_q[0] ? cur_rbyte : '0);
  assign rhi = comb ? ext_din[15:8] : (be_q[1] ? cur_rbyte : '0);

  assign cpu_ack   = last;
  assign cpu_rdata = (last && !we_q) ? {rhi, rlo} : '0;

  assign ale         = (st == S_ADDR);
  assign ext_addr    = busy ? cur_addr : '0;
  assign ext_addr_oe = (st != S_HOLD);
  assign ctrl_oe     = (st != S_HOLD);
  assign hlda_n      = (st != S_HOLD);

  assign ext_dout[7:0]  = (ale && mux_sel) ? maddr : (comb ? wd_q[7:0] : cur_wbyte);
  assign ext_dout[15:8] = comb ? wd_q[15:8] : cur_wbyte;
  assign ext_dout_oe[0] = (ale && mux_sel) || (we_q && lane_lo);
  assign ext_dout_oe[1] = we_q && lane_hi;

  assign rd_n       = !(in_data && !we_q);
  assign strobe_a_n = !(in_data && we_q && (sty || lane_lo));
  assign strobe_b_n = sty ? !(busy && odd_touch) : !(in_data && we_q && lane_hi);

  assign page = cur_addr[AW-1:PLSB];

  for (genvar i = 0; i < NCS; i++) begin : g_win
    logic [PW-1:0] base, len, off;
    assign base   = cs_base[i*PW +: PW];
    assign len    = cs_len[i*PW +: PW];
    assign off    = page - base;
    assign hit[i] = (page >= base) && (off < len);
  end

  assign cs_sel = busy ? (hit & (~hit + NCS'(1))) : '0;
  assign cs_n   = ~cs_sel;

  a_r11_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r11_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (cs_n == '1));
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda_n |-> (!ext_addr_oe && ext_dout_oe == 2'b00 && !ctrl_oe));
  a_r10_no_mid_grant: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> hlda_n);
  a_r7_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !rdy_n) |=> (in_data && $stable(ext_addr) && $stable(rd_n) && $stable(strobe_a_n)));
  a_r6_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  a_r5_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_sel && in_data && we_q) |-> (!strobe_a_n && ext_dout_oe == 2'b01));
  a_r3_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (strobe_a_n && (sty || strobe_b_n)));

endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cpu_req, cpu_we, cpu_ack;
  logic [19:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [1:0]  cpu_be;
  logic        narrow_sel, mux_sel, strobe_sel;
  logic [31:0] cs_base, cs_len;
  logic [19:0] ext_addr;
  logic        ext_addr_oe, ale, rd_n, strobe_a_n, strobe_b_n, ctrl_oe, hlda_n;
  logic [15:0] ext_dout, ext_din;
  logic [1:0]  ext_dout_oe;
  logic [3:0]  cs_n;
  logic        rdy_n = 1'b1;
  logic        hold_n;

  int n_chk = 0, n_bad = 0;
  int waits = 0;
  int wcnt  = 0;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .narrow_sel(narrow_sel), .mux_sel(mux_sel), .strobe_sel(strobe_sel),
    .cs_base(cs_base), .cs_len(cs_len), .ext_addr(ext_addr), .ext_addr_oe(ext_addr_oe),
    .ext_dout(ext_dout), .ext_dout_oe(ext_dout_oe), .ext_din(ext_din), .ale(ale),
    .rd_n(rd_n), .strobe_a_n(strobe_a_n), .strobe_b_n(strobe_b_n), .cs_n(cs_n),
    .ctrl_oe(ctrl_oe), .rdy_n(rdy_n), .hold_n(hold_n), .hlda_n(hlda_n)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] x);
    return x[7:0] ^ x[15:8] ^ {x[19:16], 4'hA};
  endfunction

  assign ext_din = narrow_sel ? {8'h00, mem_byte(ext_addr)}
                              : {mem_byte(ext_addr | 20'h1), mem_byte(ext_addr & ~20'h1)};

  function automatic logic [3:0] exp_cs(input logic [19:0] a);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b, l, pg;
      b = cs_base[i*8 +: 8]; l = cs_len[i*8 +: 8]; pg = a[19:12];
      if (pg >= b && 8'(pg - b) < l) return ~(4'b0001 << i);
    end
    return 4'hF;
  endfunction

  typedef struct {
    logic [19:0] addr;
    logic [3:0]  csn;
    logic        rd, sa, sb, we;
    logic [1:0]  lanes;
    logic [15:0] dat;
    logic [7:0]  mb;
  } beat_t;

  beat_t exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push_beat(input logic we, input logic [19:0] a, input logic [1:0] lanes, input logic [15:0] d);
    beat_t e;
    logic eff;
    eff = narrow_sel | strobe_sel;
    e.addr = a; e.we = we; e.lanes = lanes; e.dat = d;
    e.csn = exp_cs(a);
    e.rd = we;
    if (!eff) begin
      e.sa = !(we && lanes[0]);
      e.sb = !(we && lanes[1]);
    end else begin
      e.sa = !we;
      e.sb = !(narrow_sel ? a[0] : lanes[1]);
    end
    e.mb = narrow_sel ? a[7:0] : a[8:1];
    exp_q.push_back(e);
  endtask

  // monitor: pops expected bus cycles and compares them
  logic [7:0] m_mb;
  logic       m_moe;
  int         dc;
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      if (ale) begin
        m_mb = ext_dout[7:0]; m_moe = ext_dout_oe[0]; dc = 0;
      end else if (!rd_n || !strobe_a_n || (!(narrow_sel | strobe_sel) && !strobe_b_n)) begin
        dc++;
        if (rdy_n) begin
          if (exp_q.size() == 0) chk("R9 unexpected bus cycle", 1, 0);
          else begin
            beat_t e;
            logic [15:0] mk;
            e = exp_q.pop_front();
            chk("R2 address", 32'(ext_addr), 32'(e.addr));
            chk("R11 chip select", 32'(cs_n), 32'(e.csn));
            chk("R3 read strobe", 32'(rd_n), 32'(e.rd));
            if (narrow_sel) chk("R5 narrow strobes", {strobe_a_n, strobe_b_n}, {e.sa, e.sb});
            else if (strobe_sel) chk("R4 write/byte-high strobes", {strobe_a_n, strobe_b_n}, {e.sa, e.sb});
            else chk("R3 lane strobes", {strobe_a_n, strobe_b_n}, {e.sa, e.sb});
            chk("R1 lane enables", 32'(ext_dout_oe), e.we ? 32'(e.lanes) : 32'd0);
            if (e.we) begin
              mk = {{8{e.lanes[1]}}, {8{e.lanes[0]}}};
              chk("R1 lane data", 32'(ext_dout & mk), 32'(e.dat & mk));
            end
            if (mux_sel) chk("R6 shared address byte", {m_moe, m_mb}, {1'b1, e.mb});
            chk("R7 data clocks", dc, waits + 1);
          end
        end
      end
    end
  end

  // ready driver: stretch each bus cycle by 'waits' clocks
  always @(negedge clk) begin
    if (ale) wcnt = waits;
    else begin
      rdy_n = (wcnt == 0);
      if (wcnt > 0) wcnt--;
    end
  end

  task automatic run_xfer(input logic we, input logic [19:0] a, input logic [1:0] be,
                          input logic [15:0] wd, input int w, input int hold_at, input int rel_at);
    int nb, n;
    logic got, mid, early;
    logic [15:0] er;
    waits = w;
    nb = 0;
    if (!narrow_sel && !a[0] && be == 2'b11) begin
      push_beat(we, a, 2'b11, wd); nb = 1;
    end else begin
      if (be[0]) begin push_beat(we, a, narrow_sel ? 2'b01 : (a[0] ? 2'b10 : 2'b01), {wd[7:0], wd[7:0]}); nb++; end
      if (be[1]) begin
        logic [19:0] a1;
        a1 = a + 20'h1;
        push_beat(we, a1, narrow_sel ? 2'b01 : (a1[0] ? 2'b10 : 2'b01), {wd[15:8], wd[15:8]}); nb++;
      end
    end
    er = {be[1] ? mem_byte(a + 20'h1) : 8'h00, be[0] ? mem_byte(a) : 8'h00};
    @(posedge clk); #1;
    cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd; cpu_req = 1'b1;
    n = 0; got = 0; mid = 0; early = 0;
    while (!got) begin
      @(negedge clk); #1;
      n++;
      if (rel_at > 0 && n < rel_at && (ale || cpu_ack)) early = 1;
      if (rel_at > 0 && n == rel_at) hold_n = 1'b1;
      if (hold_at > 0 && n == hold_at) hold_n = 1'b0;
      if (cpu_ack) got = 1;
      else if (hold_at > 0 && !hlda_n) mid = 1;
    end
    if (!we) chk("R8 read data", 32'(cpu_rdata), 32'(er));
    if (hold_at == 0 && rel_at == 0) chk("R8 acknowledge clock", n, 1 + nb * (2 + w));
    if (hold_at > 0) chk("R10 no grant inside transfer", 32'(mid), 0);
    if (rel_at > 0) chk("R10 held request stalled", 32'(early), 0);
    @(posedge clk); #1;
    cpu_req = 1'b0;
    chk("R9 bus cycle count", exp_q.size(), 0);
    chk("R8 acknowledge one clock", 32'(cpu_ack), 0);
  endtask

  task automatic set_cfg(input logic nw, input logic mx, input logic ss);
    @(posedge clk); #1;
    narrow_sel = nw; mux_sel = mx; strobe_sel = ss;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = 2'b00;
    hold_n = 1'b1; narrow_sel = 1'b0; mux_sel = 1'b0; strobe_sel = 1'b0;
    cs_base = {8'hC0, 8'h40, 8'h08, 8'h00};
    cs_len  = {8'h01, 8'h40, 8'h20, 8'h10};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12 reset strobes", {ale, rd_n, strobe_a_n, strobe_b_n, hlda_n, cpu_ack}, 6'b011110);
    chk("R12 reset selects", 32'(cs_n), 32'hF);
    chk("R12 reset data enables", 32'(ext_dout_oe), 0);

    // 16-bit, separate bus, lane strobes (R3)
    run_xfer(1, 20'h01234, 2'b11, 16'hBEEF, 0, 0, 0);
    run_xfer(1, 20'h0A005, 2'b01, 16'h0077, 1, 0, 0);   // overlap: window 0 wins (R11)
    run_xfer(1, 20'h20003, 2'b10, 16'h9900, 0, 0, 0);
    run_xfer(0, 20'h4FFFF, 2'b11, 16'h0000, 2, 0, 0);   // odd word split (R9)
    run_xfer(0, 20'h90000, 2'b11, 16'h0000, 1, 0, 0);   // no window (R11)

    // 16-bit, write/byte-high style (R4)
    set_cfg(0, 0, 1);
    run_xfer(1, 20'hC0010, 2'b11, 16'h1234, 0, 0, 0);
    run_xfer(1, 20'h00100, 2'b01, 16'h00A5, 0, 0, 0);
    run_xfer(0, 20'h00101, 2'b01, 16'h0000, 1, 0, 0);

    // 8-bit bus forces write/byte-high style (R5)
    set_cfg(1, 0, 0);
    run_xfer(1, 20'h01000, 2'b11, 16'hC3A9, 0, 0, 0);
    run_xfer(0, 20'h00FFF, 2'b11, 16'h0000, 1, 0, 0);

    // multiplexed address (R6)
    set_cfg(0, 1, 0);
    run_xfer(1, 20'h4A2B4, 2'b11, 16'h5AA5, 0, 0, 0);
    run_xfer(0, 20'h12345, 2'b01, 16'h0000, 1, 0, 0);
    set_cfg(1, 1, 1);
    run_xfer(1, 20'h0F0FE, 2'b11, 16'h6C3D, 0, 0, 0);
    run_xfer(0, 20'h400A1, 2'b01, 16'h0000, 3, 0, 0);

    // hold handshake (R10)
    set_cfg(0, 0, 0);
    @(posedge clk); #1 hold_n = 1'b0;
    @(posedge clk); #1;
    chk("R10 hold granted", 32'(hlda_n), 0);
    chk("R10 outputs released", {ext_addr_oe, ctrl_oe, ext_dout_oe}, 4'b0000);
    run_xfer(1, 20'h02468, 2'b11, 16'hF00D, 1, 0, 5);
    set_cfg(1, 0, 0);
    run_xfer(0, 20'h03001, 2'b11, 16'h0000, 3, 3, 0);
    chk("R10 grant waits for idle", 32'(hlda_n), 1);
    @(posedge clk); #1;
    chk("R10 hold granted after transfer", 32'(hlda_n), 0);
    hold_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 hold released", 32'(hlda_n), 1);
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule